// File: doc/BRIEF.md
# Memory Ordering Issue Gate

This block sits between an in-order source of memory requests and a memory port that may finish requests in any order. Every request carries a byte address, a kind (read, write, flush or atomic exchange) and an ordering class (unordered, acquire, release or fence). Each cycle the gate decides whether the request at the head of the stream may go out to the port. It does not buffer: the head either issues in the current cycle or waits on the input. Requests never pass the head.

Every issued access gets a tag that names a slot in a small table of accesses still in flight. The table holds the 32-byte line address of each access, whether it writes, and whether it is an ordering barrier. The port returns the tag on the completion input to free the slot. Two counters track in-flight accesses and in-flight barriers (acquire or fence). An atomic exchange goes out as a locked read followed by a locked write to the same address. The input is consumed only when the write half is accepted.

Back-pressure: the issue side is valid/ready. While `iss_valid` is high and `iss_ready` is low, the issued payload stays unchanged. `req_ready` is high only in a cycle in which the head (or the write half of an atomic) is accepted by the port. The source must hold its request stable while `req_valid` is high and `req_ready` is low.

Top module: `mog_issue_gate`

## Requirements
- R1: A release-class or fence-class request (class codes 2 and 3) issues only when no access is in flight.
- R2: While any acquire-class (code 1) or fence-class access is in flight, nothing issues.
- R3: An in-flight release access does not hold back a later acquire or unordered (code 0) access.
- R4: A write (kind 1) or flush (kind 2) waits while any access to the same 32-byte line is in flight. A read (kind 0) waits while a write or flush to the same line is in flight. A read may issue while only reads to that line are in flight.
- R5: Unordered accesses to different lines issue on consecutive cycles.
- R6: An atomic exchange (kind 3) first issues a read with `iss_lock` high while `req_ready` stays low. After that read completes, it issues a write to the same address with `iss_lock` high, and `req_ready` is high in that cycle.
- R7: With NSLOT accesses in flight, issue stalls. It resumes in the cycle after a completion.
- R8: Each issued tag names a slot that is not in flight. A completion with that tag frees the slot in the next cycle.
- R9: While `iss_valid` is high and `iss_ready` is low, the issued address, kind and class stay stable and `req_ready` stays low.
- R10: After reset nothing is in flight: an unordered read issues in the first cycle it is presented, and `iss_valid` is low with no request presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Head request present |
| req_ready | output | 1 | Head request consumed this cycle |
| req_addr | input | ADDR_W | Byte address of head request |
| req_kind | input | 2 | 0 read, 1 write, 2 flush, 3 atomic exchange |
| req_class | input | 2 | 0 unordered, 1 acquire, 2 release, 3 fence |
| iss_valid | output | 1 | Access offered to memory port |
| iss_ready | input | 1 | Memory port accepts the access |
| iss_addr | output | ADDR_W | Address of issued access |
| iss_kind | output | 2 | Kind issued: 0 read, 1 write, 2 flush |
| iss_class | output | 2 | Ordering class of issued access |
| iss_lock | output | 1 | Access is a half of an atomic pair |
| iss_tag | output | TAG_W | Slot tag of issued access |
| cpl_valid | input | 1 | Completion strobe |
| cpl_tag | input | TAG_W | Tag of completed access |

## Verification
A lost or stuck barrier count shows up as a gate that never opens again. Every later request then hangs with `iss_valid` low, and the next directed scenario shows it at once. A line table that fails to record a write lets a conflicting same-line read out in the very cycle it is presented. A slot that is never freed makes the full-table stall arrive one access early. A wrong atomic phase shows as a write half on the first cycle, or as `req_ready` during the read half. Each of these faults appears at the ports within a cycle or two of the stimulus.

// File: rtl/mog_pkg.sv
package mog_pkg;
  typedef enum logic [1:0] {
    K_READ   = 2'd0,
    K_WRITE  = 2'd1,
    K_FLUSH  = 2'd2,
    K_ATOMIC = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    C_UNORD = 2'd0,
    C_ACQ   = 2'd1,
    C_REL   = 2'd2,
    C_FENCE = 2'd3
  } class_e;

  function automatic logic is_barrier(input logic [1:0] cls);
    return (cls == C_ACQ) || (cls == C_FENCE);
  endfunction

  function automatic logic needs_drain(input logic [1:0] cls);
    return (cls == C_REL) || (cls == C_FENCE);
  endfunction
endpackage

// File: rtl/mog_slot_table.sv
module mog_slot_table #(
  parameter int NSLOT = 4,
  parameter int LW    = 27,
  localparam int TW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic [LW-1:0] alloc_line,
  input  logic          alloc_wr,
  input  logic          alloc_bar,
  input  logic          free_en,
  input  logic [TW-1:0] free_tag,
  input  logic [LW-1:0] query_line,
  output logic          hit_any,
  output logic          hit_wr,
  output logic [TW-1:0] free_slot,
  output logic          free_live,
  output logic          free_bar,
  output logic [NSLOT-1:0] slot_vld
);
  logic [LW-1:0] line_q [NSLOT];
  logic [NSLOT-1:0] wr_q;
  logic [NSLOT-1:0] bar_q;
  logic [NSLOT-1:0] match;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_vld[s] <= 1'b0;
        wr_q[s]     <= 1'b0;
        bar_q[s]    <= 1'b0;
        line_q[s]   <= '0;
      end else begin
        if (free_en && free_tag == TW'(s)) slot_vld[s] <= 1'b0;
        if (alloc_en && free_slot == TW'(s)) begin
          slot_vld[s] <= 1'b1;
          wr_q[s]     <= alloc_wr;
          bar_q[s]    <= alloc_bar;
          line_q[s]   <= alloc_line;
        end
      end
    end
    assign match[s] = slot_vld[s] && (line_q[s] == query_line);
  end

  assign hit_any = |match;
  assign hit_wr  = |(match & wr_q);

  always_comb begin
    free_slot = '0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (!slot_vld[s]) free_slot = TW'(s);
    end
  end

  assign free_live = free_en && slot_vld[free_tag];
  assign free_bar  = bar_q[free_tag];
endmodule

// File: rtl/mog_counters.sv
module mog_counters #(
  parameter int NSLOT = 4,
  localparam int CW   = $clog2(NSLOT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          inc_bar,
  input  logic          dec,
  input  logic          dec_bar,
  output logic [CW-1:0] out_cnt,
  output logic [CW-1:0] bar_cnt,
  output logic          cnt_full,
  output logic          idle,
  output logic          bar_zero
);
  localparam logic [CW-1:0] CMAX = CW'(NSLOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_cnt <= '0;
      bar_cnt <= '0;
    end else begin
      if (inc && !dec && out_cnt != CMAX)        out_cnt <= out_cnt + 1'b1;
      else if (dec && !inc && out_cnt != '0)     out_cnt <= out_cnt - 1'b1;
      if (inc_bar && !dec_bar && bar_cnt != CMAX) bar_cnt <= bar_cnt + 1'b1;
      else if (dec_bar && !inc_bar && bar_cnt != '0) bar_cnt <= bar_cnt - 1'b1;
    end
  end

  assign cnt_full = (out_cnt == CMAX);
  assign idle     = (out_cnt == '0);
  assign bar_zero = (bar_cnt == '0);
endmodule

// File: rtl/mog_rules.sv
module mog_rules
  import mog_pkg::*;
(
  input  logic       cls_drain,
  input  logic       is_wr,
  input  logic       hit_any,
  input  logic       hit_wr,
  input  logic       idle,
  input  logic       bar_zero,
  input  logic       cnt_full,
  output logic       allow
);
  logic order_ok;
  logic hazard;

  always_comb begin
    order_ok = bar_zero && (!cls_drain || idle);
    hazard   = is_wr ? hit_any : hit_wr;
    allow    = order_ok && !hazard && !cnt_full;
  end
endmodule

// File: rtl/mog_issue_gate.sv
module mog_issue_gate
  import mog_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NSLOT      = 4,
  parameter int LINE_BYTES = 32,
  localparam int TAG_W     = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LW        = ADDR_W - OFF_W,
  localparam int CW        = $clog2(NSLOT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_class,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [1:0]        iss_kind,
  output logic [1:0]        iss_class,
  output logic              iss_lock,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag
);
  logic             atomic_hi;
  logic             is_atomic;
  logic [1:0]       eff_kind;
  logic             is_wr;
  logic             fire;
  logic             allow;
  logic             hit_any, hit_wr;
  logic             free_live, free_bar;
  logic [TAG_W-1:0] free_slot;
  logic [NSLOT-1:0] slot_vld;
  logic [CW-1:0]    out_cnt, bar_cnt;
  logic             cnt_full, idle, bar_zero;
  logic [LW-1:0]    req_line;

  assign is_atomic = (req_kind == K_ATOMIC);
  assign eff_kind  = is_atomic ? (atomic_hi ? 2'(K_WRITE) : 2'(K_READ)) : req_kind;
  assign is_wr     = (eff_kind != 2'(K_READ));
  assign req_line  = req_addr[ADDR_W-1:OFF_W];

  mog_slot_table #(.NSLOT(NSLOT), .LW(LW)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (fire),
    .alloc_line (req_line),
    .alloc_wr   (is_wr),
    .alloc_bar  (is_barrier(req_class)),
    .free_en    (cpl_valid),
    .free_tag   (cpl_tag),
    .query_line (req_line),
    .hit_any    (hit_any),
    .hit_wr     (hit_wr),
    .free_slot  (free_slot),
    .free_live  (free_live),
    .free_bar   (free_bar),
    .slot_vld   (slot_vld)
  );

  mog_counters #(.NSLOT(NSLOT)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (fire),
    .inc_bar  (fire && is_barrier(req_class)),
    .dec      (free_live),
    .dec_bar  (free_live && free_bar),
    .out_cnt  (out_cnt),
    .bar_cnt  (bar_cnt),
    .cnt_full (cnt_full),
    .idle     (idle),
    .bar_zero (bar_zero)
  );

  mog_rules u_rules (
    .cls_drain (needs_drain(req_class)),
    .is_wr     (is_wr),
    .hit_any   (hit_any),
    .hit_wr    (hit_wr),
    .idle      (idle),
    .bar_zero  (bar_zero),
    .cnt_full  (cnt_full),
    .allow     (allow)
  );

  assign iss_valid = req_valid && allow;
  assign fire      = iss_valid && iss_ready;
  assign req_ready = fire && (!is_atomic || atomic_hi);
  assign iss_addr  = req_addr;
  assign iss_kind  = eff_kind;
  assign iss_class = req_class;
  assign iss_lock  = req_valid && is_atomic;
  assign iss_tag   = free_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) atomic_hi <= 1'b0;
    else if (fire && is_atomic) atomic_hi <= !atomic_hi;
  end
endmodule

// File: rtl/mog_issue_gate_chk.sv
module mog_issue_gate_chk #(
  parameter int ADDR_W = 32,
  parameter int NSLOT  = 4,
  localparam int TAG_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CW    = $clog2(NSLOT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [ADDR_W-1:0] iss_addr,
  input logic [1:0]        iss_kind,
  input logic [1:0]        iss_class,
  input logic              iss_lock,
  input logic [TAG_W-1:0]  iss_tag,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic [CW-1:0]     out_cnt,
  input logic [CW-1:0]     bar_cnt,
  input logic [NSLOT-1:0]  slot_vld
);
  a_r1_drain_first: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_class[1]) |-> (out_cnt == '0));

  a_r2_barrier_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_cnt != '0) |-> !iss_valid);

  a_r6_atomic_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_kind == 2'd3) |-> (iss_kind == 2'd1 && iss_lock));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt <= CW'(NSLOT)) && (bar_cnt <= out_cnt));

  a_r8_tag_free: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |-> !slot_vld[iss_tag]);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_addr) &&
                                   $stable(iss_kind) && $stable(iss_class)));
endmodule

bind mog_issue_gate mog_issue_gate_chk #(.ADDR_W(ADDR_W), .NSLOT(NSLOT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .iss_addr  (iss_addr),
  .iss_kind  (iss_kind),
  .iss_class (iss_class),
  .iss_lock  (iss_lock),
  .iss_tag   (iss_tag),
  .req_ready (req_ready),
  .req_kind  (req_kind),
  .out_cnt   (out_cnt),
  .bar_cnt   (bar_cnt),
  .slot_vld  (slot_vld)
);

// File: tb/mog_issue_gate_tb.sv
module mog_issue_gate_tb;
  localparam int AW = 32;
  localparam int NS = 4;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_kind = '0;
  logic [1:0] req_class = '0;
  logic iss_valid;
  logic iss_ready = 1'b1;
  logic [AW-1:0] iss_addr;
  logic [1:0] iss_kind, iss_class;
  logic iss_lock;
  logic [TW-1:0] iss_tag;
  logic cpl_valid = 1'b0;
  logic [TW-1:0] cpl_tag = '0;

  int n_chk = 0;
  int n_fail = 0;
  int q[$];

  always #5 clk = ~clk;

  mog_issue_gate #(.ADDR_W(AW), .NSLOT(NS), .LINE_BYTES(32)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_kind(req_kind), .req_class(req_class),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_addr(iss_addr),
    .iss_kind(iss_kind), .iss_class(iss_class), .iss_lock(iss_lock),
    .iss_tag(iss_tag), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic present(input logic [AW-1:0] a, input logic [1:0] k, input logic [1:0] c);
    @(negedge clk);
    req_addr = a; req_kind = k; req_class = c; req_valid = 1'b1;
    #1;
  endtask

  task automatic accept(input bit drop, output int tag);
    tag = int'(iss_tag);
    q.push_back(tag);
    @(posedge clk);
    #1;
    if (drop) req_valid = 1'b0;
  endtask

  task automatic complete(input int tag);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_tag = TW'(tag);
    @(posedge clk);
    #1;
    cpl_valid = 1'b0;
    foreach (q[i]) if (q[i] == tag) begin q.delete(i); break; end
  endtask

  task automatic drain();
    while (q.size() > 0) begin
      int idx = int'($urandom % q.size());
      complete(q[idx]);
    end
  endtask

  task automatic t_reset();
    int t;
    #1;
    chk("R10 idle valid", int'(iss_valid), 0);
    present(32'h100, 2'd0, 2'd0);
    chk("R10 first read issues", int'(iss_valid), 1);
    chk("R10 req_ready", int'(req_ready), 1);
    accept(1, t);
    drain();
  endtask

  task automatic t_unordered();
    int t0, t1, t2;
    present(32'h200, 2'd0, 2'd0); chk("R5 first", int'(iss_valid), 1); accept(1, t0);
    present(32'h220, 2'd1, 2'd0); chk("R5 second", int'(iss_valid), 1); accept(1, t1);
    present(32'h240, 2'd0, 2'd0); chk("R5 third", int'(iss_valid), 1); accept(1, t2);
    chk("R8 tags distinct", int'(t0 != t1 && t1 != t2 && t0 != t2), 1);
    drain();
  endtask

  task automatic t_release();
    int ta, tb, tc, td;
    present(32'h300, 2'd1, 2'd0); accept(1, ta);
    present(32'h400, 2'd1, 2'd2);
    chk("R1 release waits", int'(iss_valid), 0);
    complete(ta);
    #1 chk("R1 release after drain", int'(iss_valid), 1);
    accept(1, tb);
    present(32'h500, 2'd0, 2'd1);
    chk("R3 acquire after release", int'(iss_valid), 1);
    accept(1, tc);
    present(32'h600, 2'd0, 2'd0);
    chk("R2 acquire blocks", int'(iss_valid), 0);
    complete(tc);
    #1 chk("R3 unordered after release", int'(iss_valid), 1);
    accept(1, td);
    drain();
  endtask

  task automatic t_fence();
    int ta, tf, tb;
    present(32'h700, 2'd0, 2'd0); accept(1, ta);
    present(32'h800, 2'd1, 2'd3);
    chk("R1 fence waits", int'(iss_valid), 0);
    complete(ta);
    #1 chk("R1 fence issues", int'(iss_valid), 1);
    accept(1, tf);
    present(32'h900, 2'd0, 2'd0);
    chk("R2 fence blocks", int'(iss_valid), 0);
    complete(tf);
    #1 chk("R2 after fence", int'(iss_valid), 1);
    accept(1, tb);
    drain();
  endtask

  task automatic t_hazard();
    int tw, to, tr1, tr2;
    present(32'hA00, 2'd1, 2'd0); accept(1, tw);
    present(32'hA04, 2'd0, 2'd0);
    chk("R4 RAW same line waits", int'(iss_valid), 0);
    present(32'hB00, 2'd0, 2'd0);
    chk("R5 other line issues", int'(iss_valid), 1);
    accept(1, to);
    complete(tw);
    present(32'hA08, 2'd0, 2'd0);
    chk("R4 read after write done", int'(iss_valid), 1);
    accept(1, tr1);
    present(32'hA1C, 2'd0, 2'd0);
    chk("R4 read after read", int'(iss_valid), 1);
    accept(1, tr2);
    present(32'hA10, 2'd1, 2'd0);
    chk("R4 WAR waits", int'(iss_valid), 0);
    present(32'hA00, 2'd2, 2'd0);
    chk("R4 flush waits", int'(iss_valid), 0);
    req_valid = 1'b0;
    drain();
  endtask

  task automatic t_atomic();
    int tr, tw;
    present(32'hC40, 2'd3, 2'd0);
    chk("R6 read half valid", int'(iss_valid), 1);
    chk("R6 read half kind", int'(iss_kind), 0);
    chk("R6 read half lock", int'(iss_lock), 1);
    chk("R6 no ready on read half", int'(req_ready), 0);
    accept(0, tr);
    chk("R6 write waits for read", int'(iss_valid), 0);
    complete(tr);
    #1;
    chk("R6 write half valid", int'(iss_valid), 1);
    chk("R6 write half kind", int'(iss_kind), 1);
    chk("R6 write half lock", int'(iss_lock), 1);
    chk("R6 write half addr", int'(iss_addr), 32'hC40);
    chk("R6 ready on write half", int'(req_ready), 1);
    accept(1, tw);
    complete(tw);
    chk("R8 table empty after atomic", q.size(), 0);
  endtask

  task automatic t_full();
    int t;
    for (int i = 0; i < NS; i++) begin
      present(AW'(32'h1000 + 32 * i), 2'd0, 2'd0);
      chk("R7 fill", int'(iss_valid), 1);
      accept(1, t);
    end
    present(32'h2000, 2'd0, 2'd0);
    chk("R7 full stalls", int'(iss_valid), 0);
    complete(q[1]);
    #1 chk("R7 resumes", int'(iss_valid), 1);
    chk("R8 reused freed tag", int'(iss_tag), 1);
    accept(1, t);
    drain();
  endtask

  task automatic t_backpressure();
    int t;
    iss_ready = 1'b0;
    present(32'hD00, 2'd1, 2'd0);
    chk("R9 valid under stall", int'(iss_valid), 1);
    chk("R9 no req_ready", int'(req_ready), 0);
    @(negedge clk); #1;
    chk("R9 addr stable", int'(iss_addr), 32'hD00);
    chk("R9 still valid", int'(iss_valid), 1);
    iss_ready = 1'b1;
    #1 chk("R9 ready passes", int'(req_ready), 1);
    accept(1, t);
    drain();
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_unordered();
    t_release();
    t_fence();
    t_hazard();
    t_atomic();
    t_full();
    t_backpressure();
    repeat (2) @(posedge clk);
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end
endmodule